// File: doc/BRIEF.md
# Chip-Select Port with Transfer Override

This block is a byte-wide (by default) general-purpose port whose pins select serial peripherals. A direction register decides, pin by pin, whether the port drives the pad or listens to it. A single data register serves both ways. Writes set the software level of the driven pins. Reads return the synchronised level of the listening pins and a constant 1 for every driven pin.

A serial transfer engine sits beside the port and offers one active-low request per pin. While a transfer runs, the engine may pull a driven pin low. The port combines the engine request with the software level so that a low from either source wins. Software hands a pin to the engine by making it an output and leaving its software bit at 1. A software 0 keeps the pin low whatever the engine does. Pins that are inputs ignore the engine entirely.

Top module: `csel_port`

## Requirements
- R1: After reset, every pin is an input (`pad_oe` all 0, `rd_dir` all 0), and `rd_port` shows the synchronised pad levels.
- R2: A cycle with `wr_dir` high loads `wdata` into the direction register, and the new value shows on `rd_dir` and `pad_oe` from the next cycle on. A bit value of 1 means output.
- R3: A cycle with `wr_lat` high updates the software level only for bits whose direction is output at that edge. Bits written for input pins are discarded and leave the stored level unchanged.
- R4: `rd_port` returns 1 in every bit position whose direction is output.
- R5: An input pin's level reaches `rd_port` through two flops. A change on `pad_i` made between edges is absent after one rising edge and present after the second.
- R6: An output pin drives the AND of its software level and its `hw_req_n` bit, so an engine request of 0 pulls it low.
- R7: When the software level of an output pin is 0, the pin stays low after the engine releases its request (`hw_req_n` back to 1).
- R8: An input pin has `pad_oe` 0 and `pad_o` 1 regardless of `hw_req_n` or the software level.
- R9: After reset, the software level of every bit is 1. A pin switched to output without any data write therefore drives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Load `wdata` into the direction register |
| wr_lat | input | 1 | Load `wdata` into the software levels of output pins |
| wdata | input | NPINS | Host write data |
| rd_dir | output | NPINS | Direction register read-back, 1 = output |
| rd_port | output | NPINS | Port read: synchronised input levels, 1 for outputs |
| hw_req_n | input | NPINS | Transfer engine pull-low requests, active low |
| pad_i | input | NPINS | Pad input levels |
| pad_o | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchroniser. Eight pins allow full-byte patterns that mix inputs and outputs within one byte. The two-stage synchroniser makes the read latency exactly two edges, so the one-edge and two-edge samples separate a missing stage from an extra one. The vector walk carries the software levels over from one vector to the next. As a result, a masked data write that leaks into input bits surfaces later, when those pins turn into outputs.

// File: rtl/csel_pkg.sv
package csel_pkg;

   // Level driven onto a pad: outputs carry the wired-AND of the software
   // level and the engine request, inputs idle at 1.
   function automatic logic pin_level(input logic is_out,
                                      input logic sw_lvl,
                                      input logic req_n);
      return is_out ? (sw_lvl & req_n) : 1'b1;
   endfunction

   // Value seen by the host for one bit of the port register.
   function automatic logic pin_readback(input logic is_out,
                                         input logic synced);
      return is_out ? 1'b1 : synced;
   endfunction

endpackage

// File: rtl/csel_sync.sv
module csel_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/csel_regs.sv
module csel_regs #(
   parameter int               WIDTH     = 8,
   parameter logic [WIDTH-1:0] LAT_RESET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_lat,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] lat_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wdata;
   end

   // Masked by the direction held at this edge: input bits keep their level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_q <= LAT_RESET;
      else if (wr_lat) lat_q <= (lat_q & ~dir_q) | (wdata & dir_q);
   end

endmodule

// File: rtl/csel_merge.sv
module csel_merge
   import csel_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] req_n,
   input  logic [WIDTH-1:0] synced,
   output logic [WIDTH-1:0] pad_o,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] rd_port
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_oe[i]  = dir_q[i];
      assign pad_o[i]   = pin_level(dir_q[i], lat_q[i], req_n[i]);
      assign rd_port[i] = pin_readback(dir_q[i], synced[i]);
   end

endmodule

// File: rtl/csel_port.sv
module csel_port #(
   parameter int                NPINS       = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [NPINS-1:0]  LAT_RESET   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_dir,
   input  logic             wr_lat,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] rd_dir,
   output logic [NPINS-1:0] rd_port,
   input  logic [NPINS-1:0] hw_req_n,
   input  logic [NPINS-1:0] pad_i,
   output logic [NPINS-1:0] pad_o,
   output logic [NPINS-1:0] pad_oe
);

   if (NPINS < 1 || NPINS > 64) begin : g_bad_width
      $error("csel_port: NPINS must lie in 1..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("csel_port: SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] dir_q;
   logic [NPINS-1:0] lat_q;
   logic [NPINS-1:0] synced;

   csel_regs #(.WIDTH(NPINS), .LAT_RESET(LAT_RESET)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dir (wr_dir),
      .wr_lat (wr_lat),
      .wdata  (wdata),
      .dir_q  (dir_q),
      .lat_q  (lat_q)
   );

   csel_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_i),
      .q     (synced)
   );

   csel_merge #(.WIDTH(NPINS)) u_merge (
      .dir_q   (dir_q),
      .lat_q   (lat_q),
      .req_n   (hw_req_n),
      .synced  (synced),
      .pad_o   (pad_o),
      .pad_oe  (pad_oe),
      .rd_port (rd_port)
   );

   assign rd_dir = dir_q;

endmodule

// File: rtl/csel_port_chk.sv
module csel_port_chk #(
   parameter int NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_dir,
   input logic             wr_lat,
   input logic [NPINS-1:0] wdata,
   input logic [NPINS-1:0] rd_port,
   input logic [NPINS-1:0] hw_req_n,
   input logic [NPINS-1:0] pad_o,
   input logic [NPINS-1:0] pad_oe
);

   AST_DIR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pad_oe == $past(wdata)); // R2

   AST_OUT_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_port & pad_oe) == pad_oe); // R4

   AST_REQ_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & ~hw_req_n & pad_o) == '0); // R6

   AST_SW_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lat && !wr_dir) |=> (pad_oe & ~$past(wdata) & pad_o) == '0); // R7

   AST_INPUT_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (~pad_oe & ~pad_o) == '0); // R8

endmodule

bind csel_port csel_port_chk #(.NPINS(NPINS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_dir   (wr_dir),
   .wr_lat   (wr_lat),
   .wdata    (wdata),
   .rd_port  (rd_port),
   .hw_req_n (hw_req_n),
   .pad_o    (pad_o),
   .pad_oe   (pad_oe)
);

// File: tb/test_csel_port.sv
module test_csel_port;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_dir = 1'b0;
   logic         wr_lat = 1'b0;
   logic [N-1:0] wdata = '0;
   logic [N-1:0] hw_req_n = '1;
   logic [N-1:0] pad_i = '0;
   logic [N-1:0] rd_dir, rd_port, pad_o, pad_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   csel_port #(.NPINS(N), .SYNC_STAGES(2)) i_csel_port (
      .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_lat(wr_lat),
      .wdata(wdata), .rd_dir(rd_dir), .rd_port(rd_port),
      .hw_req_n(hw_req_n), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
   );

   // {direction, data written, engine request, pad level}
   localparam logic [31:0] VEC [10] = '{
      32'h00_FF_FF_A5, 32'hFF_0F_FF_00, 32'hF0_00_0F_3C, 32'h0F_AA_F0_FF,
      32'hFF_FF_00_00, 32'h3C_C3_5A_81, 32'hFF_5A_A5_7E, 32'h81_00_FF_18,
      32'hFF_FF_FF_FF, 32'h66_99_0F_F0
   };

   task automatic check(input string tag, input logic [N-1:0] act,
                        input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put_dir(input logic [N-1:0] v);
      @(negedge clk); wr_dir = 1'b1; wdata = v;
      @(negedge clk); wr_dir = 1'b0;
   endtask

   task automatic put_lat(input logic [N-1:0] v);
      @(negedge clk); wr_lat = 1'b1; wdata = v;
      @(negedge clk); wr_lat = 1'b0;
   endtask

   initial begin
      #40000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] lat_m;
      pad_i = 8'h3C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pad_oe", pad_oe, 8'h00);
      check("R1 rd_dir", rd_dir, 8'h00);
      check("R1 rd_port", rd_port, 8'h3C);
      check("R8 pad_o idle", pad_o, 8'hFF);

      // R9 / R2 / R4: switch all to output without data write
      put_dir(8'hFF);
      check("R2 rd_dir", rd_dir, 8'hFF);
      check("R2 pad_oe", pad_oe, 8'hFF);
      check("R9 reset level", pad_o, 8'hFF);
      check("R4 rd_port", rd_port, 8'hFF);

      // R3: write zeros while only low nibble is output
      put_dir(8'h0F);
      put_lat(8'h00);
      put_dir(8'hFF);
      check("R3 masked write", pad_o, 8'hF0);

      // R6: engine pulls bit 0 low, then releases
      put_lat(8'hFF);
      @(negedge clk); hw_req_n = 8'hFE;
      #0; check("R6 pull low", pad_o, 8'hFE);
      @(negedge clk); hw_req_n = 8'hFF;
      #0; check("R6 release", pad_o, 8'hFF);

      // R7: software low on bit 1 survives engine release
      put_lat(8'hFD);
      @(negedge clk); hw_req_n = 8'hFD;
      #0; check("R7 during request", pad_o, 8'hFD);
      @(negedge clk); hw_req_n = 8'hFF;
      #0; check("R7 after release", pad_o, 8'hFD);

      // R8: inputs ignore requests and levels
      put_dir(8'h00);
      @(negedge clk); hw_req_n = 8'h00;
      #0; check("R8 pad_o", pad_o, 8'hFF);
      check("R8 pad_oe", pad_oe, 8'h00);
      hw_req_n = 8'hFF;

      // R5: two-edge synchroniser latency
      @(negedge clk); pad_i = 8'h00;
      repeat (3) @(negedge clk);
      pad_i = 8'h81;
      @(negedge clk);
      check("R5 after one edge", rd_port, 8'h00);
      @(negedge clk);
      check("R5 after two edges", rd_port, 8'h81);

      // Table walk with a reference model of the software levels
      put_dir(8'hFF);
      put_lat(8'hFF);
      lat_m = 8'hFF;
      for (int k = 0; k < 10; k++) begin
         logic [N-1:0] d, w, r, p, exp_o;
         {d, w, r, p} = VEC[k];
         put_dir(d);
         put_lat(w);
         lat_m = (lat_m & ~d) | (w & d);
         hw_req_n = r;
         pad_i = p;
         repeat (2) @(negedge clk);
         exp_o = (d & lat_m & r) | ~d;
         check($sformatf("R6 vec%0d pad_o", k), pad_o, exp_o);
         check($sformatf("R2 vec%0d pad_oe", k), pad_oe, d);
         check($sformatf("R4 vec%0d rd_port", k), rd_port, d | p);
      end
      hw_req_n = 8'hFF;

      // R1: reset in mid-operation restores the reset state
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 re-reset pad_oe", pad_oe, 8'h00);
      put_dir(8'hFF);
      check("R9 re-reset level", pad_o, 8'hFF);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule